// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link into a byte-wide nonvolatile memory. It runs on a fast system clock and treats the serial clock, chip select, data input and pause input as synchronous samples. It detects serial clock edges, shifts command, address and data bits in on rising edges and moves read data out on falling edges. The first byte after each chip-select fall is decoded as a command. The block then steps through the address and data phases of that command. It reads the array through a read port, passes written bytes to an external page buffer, and exchanges status bytes and write-enable requests with a status unit.

The state machine has these states: `ST_IDLE` (deselected), `ST_OPCODE` (collecting the command byte), `ST_ADDR_HI` and `ST_ADDR_LO` (address bytes), `ST_READ` (streaming array bytes), `ST_WRITE` (accepting data bytes), `ST_STAT_RD` (streaming the status byte), `ST_STAT_WR` (collecting a status byte), `ST_STAT_HELD` (status byte held, waiting for deselect), `ST_WEL_SET` and `ST_WEL_CLR` (waiting for deselect to apply an enable or disable), and `ST_IGNORE` (bad or blocked command).

The transitions are as follows:
- A chip-select fall enters `ST_OPCODE` from any state. A chip-select rise returns to `ST_IDLE` from any state.
- A complete command byte in `ST_OPCODE` leads to `ST_WEL_SET`, `ST_WEL_CLR`, `ST_STAT_RD`, `ST_STAT_WR` or `ST_ADDR_HI`, or to `ST_IGNORE` for an unknown code or a blocked command.
- A complete byte moves `ST_ADDR_HI` to `ST_ADDR_LO`.
- A complete byte in `ST_ADDR_LO` moves to `ST_READ` or `ST_WRITE`, following the command.
- A complete byte moves `ST_STAT_WR` to `ST_STAT_HELD`.
- All other states hold until deselect.

Top module: `spi_mem_cmd`

## Requirements
- R1: After reset, and whenever chip select is high, so_oe is 0 and no action pulse (wr_valid, wr_commit, sr_wr_valid, wel_set, wel_clr) is issued.
- R2: Command 0x06 followed by a byte-aligned chip-select rise gives exactly one wel_set pulse. Command 0x04 gives exactly one wel_clr pulse in the same way.
- R3: Input bits are taken most significant first on each rising serial clock edge. so changes only on falling edges. Both clock polarities at select time (idle low and idle high) work, and the first rising edge after select takes bit 7 of the command.
- R4: Command 0x03 takes a 16-bit address whose bit 15 is ignored for the default 15-bit array. It then streams bytes from rd_addr, which increments after each byte and wraps from 0x7FFF to 0x0000.
- R5: Command 0x02 takes a 16-bit address. Each following complete data byte gives one wr_valid pulse with wr_addr and wr_data. Between bytes, the low 6 address bits increment and wrap within the 64-byte page, and the upper bits stay fixed.
- R6: wr_commit pulses once at chip-select rise only if at least one data byte was received and the bit count is on a byte boundary. A partial final byte gives no commit.
- R7: If busy is 1 when a command byte completes, any command other than 0x05 is ignored. This means no pulses and so_oe stays 0 until the next select.
- R8: Command 0x05 streams sr_data, sampled again for every byte, for as long as the clock runs. This also works while busy is 1.
- R9: Command 0x01 holds the first data byte. At a byte-aligned chip-select rise it gives one sr_wr_valid pulse with that byte on sr_wr_data. Later bytes are ignored.
- R10: An unknown command byte (for example 0x07) leaves so_oe at 0 and gives no pulse for the rest of that selection.
- R11: The pause input changes state only while the serial clock is low. While paused, so_oe is 0 and serial clock and data transitions are ignored without loss of position. After release, the transfer resumes with the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock sample |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (0 = high impedance) |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array read data |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | ADDR_W | Address of the received byte |
| wr_data | output | 8 | Received data byte |
| wr_commit | output | 1 | Start of the internal array write |
| sr_data | input | 8 | Current status byte |
| busy | input | 1 | Internal write in progress |
| sr_wr_valid | output | 1 | Status write strobe |
| sr_wr_data | output | 8 | Status byte to write |
| wel_set | output | 1 | Write-enable request |
| wel_clr | output | 1 | Write-disable request |

## Verification
The pause input and a serial clock fall can arrive in the same system clock cycle. The bench provokes this by driving hold_n low on the same sample where the serial clock drops, both in the middle of an address byte and in the middle of a read byte. The rule being judged is that the falling edge still shifts one output bit before the freeze begins. After release, the byte read back must equal the expected array byte with no bit lost or repeated, and so_oe must read 0 throughout the pause.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OPC_SET_WEL = 8'h06;
    localparam logic [BYTE_W-1:0] OPC_CLR_WEL = 8'h04;
    localparam logic [BYTE_W-1:0] OPC_STAT_RD = 8'h05;
    localparam logic [BYTE_W-1:0] OPC_STAT_WR = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_MEM_RD  = 8'h03;
    localparam logic [BYTE_W-1:0] OPC_MEM_WR  = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_READ,
        ST_WRITE,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_STAT_HELD,
        ST_WEL_SET,
        ST_WEL_CLR,
        ST_IGNORE
    } cmd_state_e;
endpackage

// File: rtl/spi_pin_front.sv
module spi_pin_front (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic hold_n_i,
    output logic rise_o,
    output logic fall_o,
    output logic sel_fall_o,
    output logic sel_rise_o,
    output logic paused_o
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            paused_o <= 1'b0;
        end else begin
            sck_q <= sck_i;
            cs_q  <= cs_n_i;
            // pause may only start or end while the serial clock is low
            if (!sck_i) paused_o <= ~hold_n_i;
        end
    end

    assign rise_o     = sck_i & ~sck_q & ~paused_o & ~cs_n_i;
    assign fall_o     = ~sck_i & sck_q & ~paused_o & ~cs_n_i;
    assign sel_fall_o = ~cs_n_i & cs_q;
    assign sel_rise_o = cs_n_i & ~cs_q;

    // R11: pause level only moves after a low clock sample
    a_r11_pause_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_o != $past(paused_o)) |-> !$past(sck_i));
endmodule

// File: rtl/spi_bit_shift.sv
module spi_bit_shift
    import spi_mem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 rise_i,
    input  logic                 si_i,
    output logic [BIT_CNT_W-1:0] cnt_o,
    output logic                 byte_done_o,
    output logic [BYTE_W-1:0]    byte_o
);
    logic [BYTE_W-2:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_o <= '0;
        end else if (clear_i) begin
            cnt_o <= '0;
        end else if (rise_i) begin
            sh_q  <= {sh_q[BYTE_W-3:0], si_i};
            cnt_o <= cnt_o + BIT_CNT_W'(1);
        end
    end

    assign byte_done_o = rise_i & (cnt_o == BIT_CNT_W'(BYTE_W - 1));
    assign byte_o      = {sh_q, si_i};

    // R3: the bit position only advances on a qualified rising edge
    a_r3_count_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_i && !clear_i) |=> $stable(cnt_o));
endmodule

// File: rtl/spi_out_ser.sv
module spi_out_ser
    import spi_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              fall_i,
    input  logic              active_i,
    input  logic [BYTE_W-1:0] src_i,
    output logic              so_o,
    output logic              started_o,
    output logic              byte_end_o
);
    logic [BIT_CNT_W-1:0] ocnt_q;
    logic [BYTE_W-2:0]    osh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocnt_q    <= '0;
            osh_q     <= '0;
            so_o      <= 1'b0;
            started_o <= 1'b0;
        end else if (clear_i) begin
            ocnt_q    <= '0;
            started_o <= 1'b0;
        end else if (fall_i && active_i) begin
            started_o <= 1'b1;
            ocnt_q    <= ocnt_q + BIT_CNT_W'(1);
            if (ocnt_q == '0) begin
                so_o  <= src_i[BYTE_W-1];
                osh_q <= src_i[BYTE_W-2:0];
            end else begin
                so_o  <= osh_q[BYTE_W-2];
                osh_q <= {osh_q[BYTE_W-3:0], 1'b0};
            end
        end
    end

    assign byte_end_o = fall_i & active_i & (ocnt_q == BIT_CNT_W'(BYTE_W - 1));

    // R3: output data only moves on a falling edge
    a_r3_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fall_i && active_i) && !clear_i) |=> $stable(so_o));
endmodule

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_commit,
    input  logic [BYTE_W-1:0] sr_data,
    input  logic              busy,
    output logic              sr_wr_valid,
    output logic [BYTE_W-1:0] sr_wr_data,
    output logic              wel_set,
    output logic              wel_clr
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic                 rise, fall, sel_fall, sel_rise, paused;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic                 byte_done;
    logic [BYTE_W-1:0]    in_byte;
    logic                 so_started, out_byte_end, rd_active;
    logic [BYTE_W-1:0]    out_src;

    cmd_state_e           state, nxt;
    logic [HI_W-1:0]      addr_hi_q;
    logic [ADDR_W-1:0]    rd_ptr, wr_ptr;
    logic                 op_is_read, wr_any;
    logic [BYTE_W-1:0]    sr_byte_q;

    spi_pin_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sck_i      (sck),
        .hold_n_i   (hold_n),
        .rise_o     (rise),
        .fall_o     (fall),
        .sel_fall_o (sel_fall),
        .sel_rise_o (sel_rise),
        .paused_o   (paused)
    );

    spi_bit_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (sel_fall),
        .rise_i      (rise),
        .si_i        (si),
        .cnt_o       (bit_cnt),
        .byte_done_o (byte_done),
        .byte_o      (in_byte)
    );

    assign rd_active = (state == ST_READ) || (state == ST_STAT_RD);
    assign out_src   = (state == ST_STAT_RD) ? sr_data : rd_data;

    spi_out_ser u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (sel_fall),
        .fall_i     (fall),
        .active_i   (rd_active),
        .src_i      (out_src),
        .so_o       (so),
        .started_o  (so_started),
        .byte_end_o (out_byte_end)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (sel_rise) begin
            nxt = ST_IDLE;
        end else if (sel_fall) begin
            nxt = ST_OPCODE;
        end else begin
            unique case (state)
                ST_OPCODE: begin
                    if (byte_done) begin
                        if (busy && in_byte != OPC_STAT_RD) begin
                            nxt = ST_IGNORE;
                        end else begin
                            case (in_byte)
                                OPC_SET_WEL: nxt = ST_WEL_SET;
                                OPC_CLR_WEL: nxt = ST_WEL_CLR;
                                OPC_STAT_RD: nxt = ST_STAT_RD;
                                OPC_STAT_WR: nxt = ST_STAT_WR;
                                OPC_MEM_RD:  nxt = ST_ADDR_HI;
                                OPC_MEM_WR:  nxt = ST_ADDR_HI;
                                default:     nxt = ST_IGNORE;
                            endcase
                        end
                    end
                end
                ST_ADDR_HI: if (byte_done) nxt = ST_ADDR_LO;
                ST_ADDR_LO: if (byte_done) nxt = op_is_read ? ST_READ : ST_WRITE;
                ST_STAT_WR: if (byte_done) nxt = ST_STAT_HELD;
                ST_IDLE, ST_READ, ST_WRITE, ST_STAT_RD, ST_STAT_HELD,
                ST_WEL_SET, ST_WEL_CLR, ST_IGNORE: nxt = state;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // datapath and action outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hi_q   <= '0;
            rd_ptr      <= '0;
            wr_ptr      <= '0;
            op_is_read  <= 1'b0;
            wr_any      <= 1'b0;
            sr_byte_q   <= '0;
            wr_valid    <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            wr_commit   <= 1'b0;
            sr_wr_valid <= 1'b0;
            sr_wr_data  <= '0;
            wel_set     <= 1'b0;
            wel_clr     <= 1'b0;
        end else begin
            wr_valid    <= 1'b0;
            wr_commit   <= 1'b0;
            sr_wr_valid <= 1'b0;
            wel_set     <= 1'b0;
            wel_clr     <= 1'b0;
            if (sel_rise) begin
                if (bit_cnt == '0) begin
                    unique case (state)
                        ST_WEL_SET:   wel_set   <= 1'b1;
                        ST_WEL_CLR:   wel_clr   <= 1'b1;
                        ST_WRITE:     wr_commit <= wr_any;
                        ST_STAT_HELD: begin
                            sr_wr_valid <= 1'b1;
                            sr_wr_data  <= sr_byte_q;
                        end
                        default: ;
                    endcase
                end
            end else begin
                unique case (state)
                    ST_OPCODE: if (byte_done) op_is_read <= (in_byte == OPC_MEM_RD);
                    ST_ADDR_HI: if (byte_done) addr_hi_q <= in_byte[HI_W-1:0];
                    ST_ADDR_LO: begin
                        if (byte_done) begin
                            rd_ptr <= {addr_hi_q, in_byte};
                            wr_ptr <= {addr_hi_q, in_byte};
                            wr_any <= 1'b0;
                        end
                    end
                    ST_READ: if (out_byte_end) rd_ptr <= rd_ptr + ADDR_W'(1);
                    ST_WRITE: begin
                        if (byte_done) begin
                            wr_valid <= 1'b1;
                            wr_addr  <= wr_ptr;
                            wr_data  <= in_byte;
                            wr_any   <= 1'b1;
                            wr_ptr   <= {wr_ptr[ADDR_W-1:PAGE_W],
                                         wr_ptr[PAGE_W-1:0] + PAGE_W'(1)};
                        end
                    end
                    ST_STAT_WR: if (byte_done) sr_byte_q <= in_byte;
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr = rd_ptr;
    assign so_oe   = ~cs_n & ~paused & so_started & rd_active;

    // R11: a pause freezes the input bit position
    a_r11_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !sel_fall) |=> $stable(bit_cnt));
    // R5: page bits of the write pointer never move during a data phase
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && $past(state) == ST_WRITE)
        |-> wr_ptr[ADDR_W-1:PAGE_W] == $past(wr_ptr[ADDR_W-1:PAGE_W]));
    // R6: at most one action strobe per cycle
    a_r6_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_commit, sr_wr_valid, wel_set, wel_clr}));
    // R7: an address phase is only entered when the decode saw no busy
    a_r7_busy_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_HI && $past(state) == ST_OPCODE) |-> !$past(busy));
    // R10: an ignored selection stays silent
    a_r10_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE && $past(state) == ST_IGNORE)
        |-> !so_oe && !wr_valid && !wr_commit && !sr_wr_valid && !wel_set && !wel_clr);
    // R2: enable and disable requests are single-cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set || wel_clr) |=> !(wel_set || wel_clr));
endmodule

// File: tb/sim_spi_mem_cmd.sv
`timescale 1ns/1ps
module sim_spi_mem_cmd;
    localparam int HALF = 4;
    localparam int BUSY_CLKS = 3000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe, wr_valid, wr_commit, sr_wr_valid, wel_set, wel_clr;
    logic [14:0] rd_addr, wr_addr;
    logic [7:0] rd_data = 8'h00, wr_data, sr_wr_data, sr_data;
    logic busy;

    int n_chk = 0, n_fail = 0;
    int n_wrv = 0, n_com = 0, n_srw = 0, n_set = 0, n_clr = 0;
    int busy_cnt = 0;
    logic wel_m = 1'b0;
    logic [7:0] srh = 8'h00, last_srw = 8'h00, exp_srh = 8'h00;
    logic cs_prev = 1'b1;
    logic [7:0] wmem [int];
    logic [7:0] rmem [int];
    int pa [$];
    logic [7:0] pd [$];
    logic [7:0] wbuf [8];

    always #2.5 clk = ~clk;

    spi_mem_cmd u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .sr_data(sr_data), .busy(busy), .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data),
        .wel_set(wel_set), .wel_clr(wel_clr));

    function automatic logic [7:0] pat(int a);
        return 8'(a) ^ 8'(a >> 7) ^ 8'h5A;
    endfunction
    function automatic logic [7:0] mem_look(int a);
        return wmem.exists(a) ? wmem[a] : pat(a);
    endfunction
    function automatic logic [7:0] exp_rd(int a);
        return rmem.exists(a) ? rmem[a] : pat(a);
    endfunction
    function automatic logic [7:0] exp_sr(logic w, logic b);
        return {exp_srh[7:2], w, b};
    endfunction

    assign busy    = (busy_cnt != 0);
    assign sr_data = {srh[7:2], wel_m, busy};

    // surrounding memory, page buffer and status unit
    always @(negedge clk) begin
        if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
        if (!cs_n && cs_prev) begin pa.delete(); pd.delete(); end
        cs_prev = cs_n;
        if (wr_valid) begin n_wrv++; pa.push_back(int'(wr_addr)); pd.push_back(wr_data); end
        if (wr_commit) begin
            n_com++;
            foreach (pa[i]) wmem[pa[i]] = pd[i];
            pa.delete(); pd.delete();
            busy_cnt = BUSY_CLKS; wel_m = 1'b0;
        end
        if (sr_wr_valid) begin n_srw++; srh = sr_wr_data; last_srw = sr_wr_data; busy_cnt = BUSY_CLKS; wel_m = 1'b0; end
        if (wel_set) begin n_set++; wel_m = 1'b1; end
        if (wel_clr) begin n_clr++; wel_m = 1'b0; end
        rd_data = mem_look(int'(rd_addr));
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin(input bit m3);
        sck = m3; tick(HALF); cs_n = 1'b0; tick(HALF);
    endtask
    task automatic cs_end(input bit m3);
        if (!m3) sck = 1'b0;
        tick(HALF); cs_n = 1'b1; tick(HALF + 2);
    endtask

    task automatic xbit(input logic b, output logic so_s, output logic oe_s);
        sck = 1'b0; si = b; tick(HALF);
        sck = 1'b1; tick(HALF);
        so_s = so; oe_s = so_oe;
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_and, output logic oe_or);
        logic s, o;
        oe_and = 1'b1; oe_or = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            xbit(tx[i], s, o);
            rx[i] = s; oe_and &= o; oe_or |= o;
        end
    endtask

    task automatic do_cmd(input logic [7:0] op, input bit m3);
        logic [7:0] r; logic a, o;
        cs_begin(m3); xbyte(op, r, a, o); cs_end(m3);
    endtask

    task automatic do_read(input logic [15:0] addr, input int n, input bit m3, input bit expect_out, input string req);
        logic [7:0] r; logic a, o;
        int ea;
        cs_begin(m3);
        xbyte(8'h03, r, a, o); xbyte(addr[15:8], r, a, o); xbyte(addr[7:0], r, a, o);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r, a, o);
            ea = (int'(addr) + i) & 32'h7FFF;
            if (expect_out) chk(a && r == exp_rd(ea), req, {23'd0, a, r}, {24'd1, exp_rd(ea)});
            else            chk(!o, req, {31'd0, o}, 32'd0);
        end
        cs_end(m3);
    endtask

    task automatic do_write(input logic [15:0] addr, input int n, input bit m3, input bit apply);
        logic [7:0] r; logic a, o;
        int ea;
        cs_begin(m3);
        xbyte(8'h02, r, a, o); xbyte(addr[15:8], r, a, o); xbyte(addr[7:0], r, a, o);
        for (int i = 0; i < n; i++) xbyte(wbuf[i], r, a, o);
        cs_end(m3);
        if (apply)
            for (int i = 0; i < n; i++) begin
                ea = (int'(addr) & 32'h7FC0) | ((int'(addr) + i) & 32'h3F);
                rmem[ea] = wbuf[i];
            end
    endtask

    task automatic do_rdsr(input int n, input bit m3, input logic [7:0] expv, input string req);
        logic [7:0] r; logic a, o;
        cs_begin(m3);
        xbyte(8'h05, r, a, o);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r, a, o);
            chk(a && r == expv, req, {23'd0, a, r}, {24'd1, expv});
        end
        cs_end(m3);
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 5000 && busy; k++) tick(1);
        tick(4);
    endtask

    initial begin
        tick(150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r; logic a, o, s;
        int b_wrv, b_com, b_set, b_clr, b_srw;
        void'($urandom(32'd24681));
        tick(5); rst_n = 1'b1; tick(5);

        // R1: reset state
        chk(so_oe == 1'b0 && n_wrv + n_com + n_srw + n_set + n_clr == 0, "R1 reset quiet",
            {31'd0, so_oe}, 32'd0);
        cs_n = 1'b0; tick(6);
        chk(so_oe == 1'b0, "R1 selected idle", {31'd0, so_oe}, 32'd0);
        cs_n = 1'b1; tick(6);

        // R2 / R3: enable and disable in both clock polarities
        b_set = n_set; do_cmd(8'h06, 1'b0);
        chk(n_set == b_set + 1, "R2 enable mode0", n_set - b_set, 1);
        b_clr = n_clr; do_cmd(8'h04, 1'b1);
        chk(n_clr == b_clr + 1, "R2 R3 disable mode3", n_clr - b_clr, 1);
        do_rdsr(1, 1'b0, exp_sr(1'b0, 1'b0), "R8 status idle");

        // R4: read across array wrap, bit 15 ignored, both polarities
        do_read(16'hFFFE, 4, 1'b0, 1'b1, "R4 wrap read mode0");
        do_read(16'h1234, 3, 1'b1, 1'b1, "R4 R3 read mode3");

        // R5 / R6: page wrapping write
        do_cmd(8'h06, 1'b1);
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
        b_wrv = n_wrv; b_com = n_com;
        do_write(16'h013E, 4, 1'b1, 1'b1);
        chk(n_wrv == b_wrv + 4, "R5 byte strobes", n_wrv - b_wrv, 4);
        chk(n_com == b_com + 1, "R6 commit", n_com - b_com, 1);

        // R7 / R8: busy window
        b_wrv = n_wrv; b_com = n_com; b_set = n_set;
        wbuf[0] = 8'h11;
        do_write(16'h0200, 1, 1'b0, 1'b0);
        chk(n_wrv == b_wrv && n_com == b_com, "R7 write blocked", n_wrv - b_wrv + n_com - b_com, 0);
        do_read(16'h0010, 1, 1'b0, 1'b0, "R7 read blocked");
        do_cmd(8'h06, 1'b0);
        chk(n_set == b_set, "R7 enable blocked", n_set - b_set, 0);
        do_rdsr(2, 1'b0, exp_sr(1'b0, 1'b1), "R8 status busy first");
        do_rdsr(2, 1'b1, exp_sr(1'b0, 1'b1), "R8 status busy again");
        wait_ready();
        do_read(16'h0100, 2, 1'b0, 1'b1, "R5 page wrapped bytes");
        do_read(16'h013E, 2, 1'b1, 1'b1, "R5 page tail bytes");
        do_read(16'h0200, 1, 1'b0, 1'b1, "R7 blocked write left data");

        // R6: partial byte gives no commit
        do_cmd(8'h06, 1'b0);
        b_com = n_com;
        cs_begin(1'b0);
        xbyte(8'h02, r, a, o); xbyte(8'h03, r, a, o); xbyte(8'h00, r, a, o);
        xbyte(8'h77, r, a, o);
        for (int i = 0; i < 3; i++) xbit(1'b1, s, o);
        cs_end(1'b0);
        tick(4);
        chk(n_com == b_com, "R6 partial no commit", n_com - b_com, 0);
        do_read(16'h0300, 1, 1'b0, 1'b1, "R6 partial left data");

        // R9: status write with trailing byte
        b_srw = n_srw;
        cs_begin(1'b1);
        xbyte(8'h01, r, a, o); xbyte(8'h8C, r, a, o); xbyte(8'h00, r, a, o);
        cs_end(1'b1);
        exp_srh = 8'h8C;
        chk(n_srw == b_srw + 1 && last_srw == 8'h8C, "R9 status write", last_srw, 8'h8C);
        wait_ready();
        do_rdsr(1, 1'b0, exp_sr(1'b0, 1'b0), "R9 R8 status readback");

        // R10: unknown command
        b_wrv = n_wrv; b_set = n_set; b_clr = n_clr; b_com = n_com; b_srw = n_srw;
        cs_begin(1'b0);
        xbyte(8'h07, r, a, o); xbyte(8'h02, r, a, o); xbyte(8'h06, r, a, o);
        chk(!o, "R10 output stays off", {31'd0, o}, 32'd0);
        cs_end(1'b0);
        chk(n_wrv + n_set + n_clr + n_com + n_srw == b_wrv + b_set + b_clr + b_com + b_srw,
            "R10 no action", n_wrv + n_set + n_clr + n_com + n_srw, b_wrv + b_set + b_clr + b_com + b_srw);

        // R11: pause in address and in data, pause entered with a clock fall
        cs_begin(1'b0);
        xbyte(8'h03, r, a, o); xbyte(8'h04, r, a, o);
        for (int i = 7; i >= 5; i--) xbit(1'(8'h56 >> i), s, o);
        sck = 1'b0; hold_n = 1'b0; si = 1'b1; tick(HALF);
        for (int k = 0; k < 3; k++) begin sck = 1'b1; si = ~si; tick(HALF); sck = 1'b0; tick(HALF); end
        hold_n = 1'b1; tick(HALF);
        for (int i = 4; i >= 0; i--) xbit(1'(8'h56 >> i), s, o);
        for (int i = 7; i >= 4; i--) begin xbit(1'b0, s, o); r[i] = s; end
        sck = 1'b0; hold_n = 1'b0; tick(HALF);
        chk(so_oe == 1'b0, "R11 output off in pause", {31'd0, so_oe}, 32'd0);
        sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        hold_n = 1'b1; tick(HALF);
        sck = 1'b1; tick(HALF); r[3] = so;
        for (int i = 2; i >= 0; i--) begin xbit(1'b0, s, o); r[i] = s; end
        chk(r == exp_rd(16'h0456), "R11 byte across pauses", r, exp_rd(16'h0456));
        // pause request with clock high has no effect
        sck = 1'b0; tick(HALF); sck = 1'b1; hold_n = 1'b0; tick(HALF);
        chk(so_oe == 1'b1, "R11 high clock pause ignored", {31'd0, so_oe}, 32'd1);
        hold_n = 1'b1; r[7] = so;
        for (int i = 6; i >= 0; i--) begin xbit(1'b0, s, o); r[i] = s; end
        chk(r == exp_rd(16'h0457), "R11 R4 next byte intact", r, exp_rd(16'h0457));
        cs_end(1'b0);

        // random writes then readback
        for (int t = 0; t < 4; t++) begin
            logic [15:0] ad; int n;
            ad = 16'($urandom); n = 1 + int'($urandom % 5);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_cmd(8'h06, 1'($urandom));
            b_wrv = n_wrv;
            do_write(ad, n, 1'($urandom), 1'b1);
            chk(n_wrv == b_wrv + n, "R5 random write strobes", n_wrv - b_wrv, n);
            wait_ready();
            do_read({ad[15:6], 6'd0}, 64, 1'b0, 1'b1, "R5 random page readback");
        end
        // random reads
        for (int t = 0; t < 16; t++)
            do_read(16'($urandom), 1 + int'($urandom % 3), 1'($urandom), 1'b1, "R4 random read");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule